// File: doc/BRIEF.md
# Predicated Vector Gather-Load Sequencer

The block loads 32-bit signed words from scattered memory locations into the 64-bit lanes of a vector. A start pulse supplies a 64-bit scalar base, a vector of per-lane 64-bit index elements, a predicate with one bit per vector byte, and three mode bits. For every enabled lane the block forms an address from the base and that lane's index and reads one word over a single-outstanding request/response port. It sign-extends the word into the lane. Lanes that are not enabled read nothing and are returned as zero.

Three mode bits select the addressing. `off_wide` picks the full 64-bit index or only its low 32 bits. `ext_signed` extends those 32 bits as signed or unsigned. `scaled` multiplies the offset by four. These give the four modes: 32-bit scaled, 32-bit unscaled, 64-bit scaled and 64-bit unscaled. When the base comes from the stack pointer (`base_is_sp`), it must be 16-byte aligned before any read is made. A read error also stops the operation. Either fault reports `fault` together with `done` and leaves `result` as it was.

The controller is a five-state machine:
- IDLE leaves on `start`. It goes to DONE when the stack-pointer base is misaligned and at least one lane is active, and to SCAN otherwise.
- SCAN picks the next active lane at or above the cursor. It goes to REQ when one is found, and to DONE (publishing the result) when none is left.
- REQ holds the request until `req_ready`, then goes to WAIT.
- WAIT goes back to SCAN on a good response and to DONE on an error response.
- DONE lasts one cycle and returns to IDLE.

Top module: `vgather_seq`

## Requirements
- R1: Each enabled lane receives its 32-bit memory word sign-extended to 64 bits, at bits [64*e+63 : 64*e] of `result`.
- R2: With `off_wide`=0 and `ext_signed`=0, the offset is index bits [31:0] of the lane, zero-extended; bits [63:32] of the element are ignored.
- R3: With `off_wide`=0 and `ext_signed`=1, the offset is index bits [31:0], sign-extended from bit 31.
- R4: With `off_wide`=1, the whole 64-bit index element is the offset, taken as unsigned, and `ext_signed` has no effect.
- R5: The address is base + offset*4 when `scaled`=1 and base + offset when `scaled`=0, modulo 2^64.
- R6: Lane e is enabled only when `pred` bit 8*e is 1; other predicate bits have no effect. A disabled lane issues no request and reads back as zero.
- R7: Requests for enabled lanes are issued in ascending lane order, exactly one per enabled lane.
- R8: With no enabled lane, no request is issued, `fault` stays 0 even for a misaligned stack-pointer base, and `result` becomes all zeros with a `done` pulse.
- R9: With `base_is_sp`=1, base bits [3:0] not all zero and at least one enabled lane, `done` and `fault` pulse together, no request is issued and `result` is unchanged.
- R10: An error response ends the operation without further requests; `done` and `fault` pulse together and `result` keeps its previous value.
- R11: Once raised, `req_valid` stays high with a stable `req_addr` until `req_ready`, and no new request is raised while a read is outstanding.
- R12: `done` is a single-cycle pulse, and `start` is ignored while `busy` is 1.
- R13: After reset `result` is zero and `done`, `fault`, `req_valid` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken in IDLE only) |
| base | input | 64 | Scalar base address |
| base_is_sp | input | 1 | Base comes from the stack pointer; alignment is checked |
| index_vec | input | VEC_BITS | Per-lane 64-bit index elements |
| pred | input | VEC_BITS/8 | Predicate, one bit per vector byte |
| off_wide | input | 1 | 1: 64-bit offset, 0: 32-bit offset |
| ext_signed | input | 1 | Sign-extend 32-bit offsets when 1 |
| scaled | input | 1 | Multiply offset by 4 when 1 |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | 64 | Read address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read word |
| rsp_err | input | 1 | Read response is an error |
| result | output | VEC_BITS | Gathered vector |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Fault flag, valid with done |
| busy | output | 1 | Operation in progress |

## Verification
Two functions can fall into the same cycle: an error response can arrive on the last enabled lane, where it competes with normal completion. If completion wins, the partly gathered vector would be published without a fault. The bench injects the error at the last enabled lane's address and expects `done` with `fault`, all lanes' requests logged, and `result` equal to the vector of the previous good run. A second overlap, a `start` arriving mid-operation with a different base, is judged by checking that every logged address still comes from the first base.

// File: rtl/gth_pkg.sv
`timescale 1ns/1ps
package gth_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_REQ,
        S_WAIT,
        S_DONE
    } gth_state_e;

    function automatic logic [63:0] gth_sext32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

endpackage

// File: rtl/gth_addr_gen.sv
`timescale 1ns/1ps
module gth_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int NARROW_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] idx,
    input  logic              off_wide,
    input  logic              ext_signed,
    input  logic              scaled,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - NARROW_W;

    logic [ADDR_W-1:0] offset;
    logic              fill;

    always_comb begin
        fill = ext_signed & idx[NARROW_W-1];
        if (off_wide) begin
            offset = idx;
        end else begin
            offset = {{HI_W{fill}}, idx[NARROW_W-1:0]};
        end
        addr = base + (scaled ? {offset[ADDR_W-3:0], 2'b00} : offset);
    end
endmodule

// File: rtl/gth_lane_pick.sv
`timescale 1ns/1ps
module gth_lane_pick #(
    parameter int LANES = 4,
    parameter int LIDX_W = 2,
    parameter int CUR_W = 3
) (
    input  logic [LANES-1:0]  act,
    input  logic [CUR_W-1:0]  cursor,
    output logic              found,
    output logic [LIDX_W-1:0] lane
);
    always_comb begin
        found = 1'b0;
        lane  = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (act[i] && (CUR_W'(i) >= cursor)) begin
                found = 1'b1;
                lane  = LIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vgather_seq.sv
`timescale 1ns/1ps
module vgather_seq #(
    parameter int VEC_BITS = 256,
    parameter int LANE_W = 64,
    parameter int WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LANE_W-1:0]     base,
    input  logic                  base_is_sp,
    input  logic [VEC_BITS-1:0]   index_vec,
    input  logic [VEC_BITS/8-1:0] pred,
    input  logic                  off_wide,
    input  logic                  ext_signed,
    input  logic                  scaled,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [LANE_W-1:0]     req_addr,
    input  logic                  rsp_valid,
    input  logic [WORD_W-1:0]     rsp_data,
    input  logic                  rsp_err,
    output logic [VEC_BITS-1:0]   result,
    output logic                  done,
    output logic                  fault,
    output logic                  busy
);
    import gth_pkg::*;

    localparam int LANES  = VEC_BITS / LANE_W;
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CUR_W  = LIDX_W + 1;
    localparam int PBITS  = LANE_W / 8;

    gth_state_e state_q, state_d;

    logic [LANES-1:0]    act_in, act_q;
    logic [VEC_BITS-1:0] idx_q, acc_q, result_q;
    logic [LANE_W-1:0]   base_q;
    logic                wide_q, sgn_q, scl_q, fault_q;
    logic [CUR_W-1:0]    cur_q;
    logic [LIDX_W-1:0]   lane_q, pick_lane;
    logic                pick_found;
    logic                any_in, misaligned_in;
    logic                unused_pred_bits;

    for (genvar e = 0; e < LANES; e++) begin : g_lane_en
        assign act_in[e] = pred[PBITS*e];
    end
    assign unused_pred_bits = ^pred;

    assign any_in        = |act_in;
    assign misaligned_in = base_is_sp & (|base[3:0]);

    gth_lane_pick #(.LANES(LANES), .LIDX_W(LIDX_W), .CUR_W(CUR_W)) u_pick (
        .act    (act_q),
        .cursor (cur_q),
        .found  (pick_found),
        .lane   (pick_lane)
    );

    gth_addr_gen #(.ADDR_W(LANE_W), .NARROW_W(WORD_W)) u_addr (
        .base       (base_q),
        .idx        (idx_q[lane_q*LANE_W +: LANE_W]),
        .off_wide   (wide_q),
        .ext_signed (sgn_q),
        .scaled     (scl_q),
        .addr       (req_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = (any_in && misaligned_in) ? S_DONE : S_SCAN;
            S_SCAN: state_d = pick_found ? S_REQ : S_DONE;
            S_REQ:  if (req_ready) state_d = S_WAIT;
            S_WAIT: if (rsp_valid) state_d = rsp_err ? S_DONE : S_SCAN;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            act_q    <= '0;
            idx_q    <= '0;
            acc_q    <= '0;
            result_q <= '0;
            base_q   <= '0;
            wide_q   <= 1'b0;
            sgn_q    <= 1'b0;
            scl_q    <= 1'b0;
            fault_q  <= 1'b0;
            cur_q    <= '0;
            lane_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (start) begin
                    act_q   <= act_in;
                    idx_q   <= index_vec;
                    base_q  <= base;
                    wide_q  <= off_wide;
                    sgn_q   <= ext_signed;
                    scl_q   <= scaled;
                    acc_q   <= '0;
                    cur_q   <= '0;
                    fault_q <= any_in & misaligned_in;
                end
                S_SCAN: begin
                    if (pick_found) lane_q <= pick_lane;
                    else            result_q <= acc_q;
                end
                S_WAIT: if (rsp_valid) begin
                    if (rsp_err) begin
                        fault_q <= 1'b1;
                    end else begin
                        acc_q[lane_q*LANE_W +: LANE_W] <= gth_sext32(rsp_data);
                        cur_q <= {1'b0, lane_q} + CUR_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_valid = (state_q == S_REQ);
        done      = (state_q == S_DONE);
        fault     = (state_q == S_DONE) && fault_q;
        busy      = (state_q != S_IDLE);
        result    = result_q;
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    p_active_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> act_q[lane_q]);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fault_keeps_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable(result));

    p_misaligned_noread_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && any_in && misaligned_in) |=> (done && fault && !req_valid));

    p_none_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && !any_in) |=> (!req_valid && !fault));

endmodule

// File: tb/test_vgather_seq.sv
`timescale 1ns/1ps
module test_vgather_seq;
    localparam int VB = 256;
    localparam int NL = VB / 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [63:0]    base = '0;
    logic           base_is_sp = 1'b0;
    logic [VB-1:0]  index_vec = '0;
    logic [VB/8-1:0] pred = '0;
    logic           off_wide = 1'b0, ext_signed = 1'b0, scaled = 1'b0;
    logic           req_valid, req_ready;
    logic [63:0]    req_addr;
    logic           rsp_valid, rsp_err;
    logic [31:0]    rsp_data;
    logic [VB-1:0]  result;
    logic           done, fault, busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vgather_seq #(.VEC_BITS(VB)) i_vgather_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .base_is_sp(base_is_sp),
        .index_vec(index_vec), .pred(pred), .off_wide(off_wide), .ext_signed(ext_signed),
        .scaled(scaled), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err), .result(result),
        .done(done), .fault(fault), .busy(busy)
    );

    function automatic logic [31:0] memf(input logic [63:0] a);
        return a[31:0] * 32'h9E3779B1 + 32'h01234567;
    endfunction

    // memory model
    logic [63:0] mlog [64];
    int          nlog = 0;
    int          cyc_n = 0;
    logic        pend = 1'b0, dly = 1'b0;
    logic [63:0] paddr = '0;
    logic        err_en = 1'b0;
    logic [63:0] err_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            req_ready <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            pend      <= 1'b0;
        end else begin
            cyc_n     <= cyc_n + 1;
            req_ready <= (cyc_n % 3) != 2;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if (req_valid && req_ready) begin
                mlog[nlog % 64] <= req_addr;
                nlog  <= nlog + 1;
                pend  <= 1'b1;
                paddr <= req_addr;
                dly   <= cyc_n[0];
            end else if (pend) begin
                if (dly) dly <= 1'b0;
                else begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= memf(paddr);
                    rsp_err   <= err_en && (paddr == err_addr);
                    pend      <= 1'b0;
                end
            end
        end
    end

    // protocol monitor (R11)
    int          hold_viol = 0;
    logic        pv = 1'b0, pr = 1'b0;
    logic [63:0] pa = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv && !pr && (!req_valid || req_addr != pa)) hold_viol++;
            if (req_valid && pend) hold_viol++;
        end
        pv = req_valid; pr = req_ready; pa = req_addr;
    end

    task automatic chk(input string tag, input logic [VB-1:0] act, input logic [VB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] calc_addr(input logic [63:0] b, input logic [63:0] ix,
                                              input logic w, input logic s, input logic sc);
        logic [63:0] o;
        if (w) o = ix;
        else if (s) o = {{32{ix[31]}}, ix[31:0]};
        else o = {32'd0, ix[31:0]};
        return sc ? b + o * 64'd4 : b + o;
    endfunction

    logic [VB-1:0] last_good = '0;

    task automatic run_op(input string tag, input logic [63:0] b, input logic sp,
                          input logic [VB-1:0] ix, input logic [VB/8-1:0] p,
                          input logic w, input logic s, input logic sc,
                          input int err_lane, input logic poke);
        logic [63:0]   ea [NL];
        int            nexp = 0;
        logic          anyl = 1'b0, efault = 1'b0, stopped = 1'b0;
        logic [VB-1:0] tmp = '0, eres;
        int            n0, waited = 0;
        logic          got = 1'b0, gfault = 1'b0;
        logic [VB-1:0] gres = '0;
        for (int e = 0; e < NL; e++) anyl |= p[8*e];
        eres = last_good;
        err_en = 1'b0;
        if (sp && b[3:0] != 4'd0 && anyl) efault = 1'b1;
        else begin
            for (int e = 0; e < NL; e++) begin
                if (p[8*e] && !stopped) begin
                    ea[nexp] = calc_addr(b, ix[e*64 +: 64], w, s, sc);
                    if (e == err_lane) begin
                        efault = 1'b1; stopped = 1'b1;
                        err_en = 1'b1; err_addr = ea[nexp];
                    end else begin
                        tmp[e*64 +: 64] = {{32{memf(ea[nexp])[31]}}, memf(ea[nexp])};
                    end
                    nexp++;
                end
            end
            if (!efault) eres = tmp;
        end
        @(negedge clk);
        n0 = nlog;
        base = b; base_is_sp = sp; index_vec = ix; pred = p;
        off_wide = w; ext_signed = s; scaled = sc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got && waited < 3000) begin
            if (poke && waited == 3) begin base = b + 64'h1000; start = 1'b1; end
            if (poke && waited == 4) begin base = b; start = 1'b0; end
            if (done) begin got = 1'b1; gfault = fault; gres = result; end
            else begin @(negedge clk); waited++; end
        end
        start = 1'b0;
        chk({tag, " R12 done seen"}, VB'(got), VB'(1));
        chk({tag, " fault flag R9 R10"}, VB'(gfault), VB'(efault));
        chk({tag, " result R1 R6"}, gres, eres);
        chk({tag, " request count R7"}, VB'(nlog - n0), VB'(nexp));
        for (int k = 0; k < nexp && k < (nlog - n0); k++)
            chk({tag, " address order R5 R7"}, VB'(mlog[(n0 + k) % 64]), VB'(ea[k]));
        @(negedge clk);
        chk({tag, " done single pulse R12"}, VB'(done), VB'(0));
        if (!efault) last_good = eres;
        err_en = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R13 reset outputs", VB'({done, fault, req_valid, busy}), VB'(0));
        chk("R13 reset result", result, '0);
    endtask

    task automatic t_zext_scaled();
        run_op("R2 zext scaled", 64'h0000_1000_0000_0000, 1'b0,
               {64'hFFFF_0000_8000_0010, 64'h1234_5678_0000_0004, 64'hDEAD_BEEF_FFFF_FFF0, 64'h0000_0000_0000_0001},
               32'h01010101, 1'b0, 1'b0, 1'b1, -1, 1'b0);
    endtask

    task automatic t_sext_unscaled();
        run_op("R3 sext unscaled", 64'h0000_2000_0000_0100, 1'b0,
               {64'h0000_0000_FFFF_FFFC, 64'hAAAA_0000_8000_0000, 64'h0000_0000_0000_0040, 64'h5555_5555_FFFF_FF00},
               32'h01010101, 1'b0, 1'b1, 1'b0, -1, 1'b0);
    endtask

    task automatic t_wide();
        run_op("R4 wide offset", 64'h0000_0000_0000_8000, 1'b0,
               {64'h8000_0000_0000_0004, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_0000_0100},
               32'h01010101, 1'b1, 1'b1, 1'b1, -1, 1'b0);
    endtask

    task automatic t_sparse();
        run_op("R6 sparse predicate", 64'h0000_0000_0004_0000, 1'b0,
               {64'h30, 64'h20, 64'h10, 64'h00},
               32'h01000102, 1'b0, 1'b0, 1'b1, -1, 1'b0);
    endtask

    task automatic t_none();
        run_op("R8 no active lane", 64'h0000_0000_0000_0008, 1'b1,
               {64'h3, 64'h2, 64'h1, 64'h0},
               32'hFEFEFEFE, 1'b0, 1'b0, 1'b1, -1, 1'b0);
    endtask

    task automatic t_sp();
        run_op("R9 aligned sp", 64'h0000_7FFF_FFF0_0000, 1'b1,
               {64'h3, 64'h2, 64'h1, 64'h0},
               32'h01010001, 1'b0, 1'b0, 1'b1, -1, 1'b0);
        run_op("R9 misaligned sp", 64'h0000_7FFF_FFF0_0008, 1'b1,
               {64'h7, 64'h6, 64'h5, 64'h4},
               32'h00000100, 1'b0, 1'b0, 1'b1, -1, 1'b0);
    endtask

    task automatic t_err();
        run_op("R10 error mid", 64'h0000_0000_0010_0000, 1'b0,
               {64'h40, 64'h30, 64'h20, 64'h10},
               32'h01010101, 1'b0, 1'b0, 1'b1, 2, 1'b0);
        run_op("R10 error on last lane", 64'h0000_0000_0020_0000, 1'b0,
               {64'h44, 64'h33, 64'h22, 64'h11},
               32'h01010101, 1'b0, 1'b0, 1'b0, 3, 1'b0);
    endtask

    task automatic t_poke();
        run_op("R12 start while busy", 64'h0000_0000_0030_0000, 1'b0,
               {64'h9, 64'h7, 64'h5, 64'h3},
               32'h01010101, 1'b0, 1'b0, 1'b1, -1, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_zext_scaled();
        t_sext_unscaled();
        t_wide();
        t_sparse();
        t_none();
        t_sp();
        t_err();
        t_poke();
        chk("R11 request hold and single outstanding", VB'(hold_viol), VB'(0));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule